// File: doc/BRIEF.md
# Block Move Operand Resolver

This block takes the two instruction words of a block-move command and works out the two operands the transfer engine needs: a 24-bit byte count and a 32-bit physical data address. The first word carries the command fields: instruction type, two addressing-mode selects, a direction opcode, the bus phase and an inline count. The second word carries an address, a pointer, or a signed displacement, depending on the mode. The block accepts one instruction at a time. When the mode calls for it, the block reads memory through a simple level request / one-cycle valid read port. When both operands are known it presents them, together with the phase and opcode, and pulses `done`.

Three modes are resolved. In direct mode no memory read is needed. In pointer mode one read at the address in word 1 returns the real data address. In table mode the low 24 bits of word 1 are sign-extended and added to a loadable base register. Two back-to-back reads then return the count (first) and the address (next word). A word 0 with both mode selects set, or with a type other than block move, is rejected. Program sequencing and the data movement itself belong to neighbouring blocks.

Top module: `bmove_operand_resolver`

## Requirements
- R1: After synchronous reset, `instr_ready` is 1 and `done`, `rd_req`, `illegal`, `align_err`, `xfer_count` and `xfer_addr` are 0.
- R2: Direct mode (word 0 bits 31-30 = 00, bit 29 = 0, bit 28 = 0): `done` pulses in the cycle after acceptance, with `xfer_count` = word 0 bits 23-0 and `xfer_addr` = word 1. No read is issued.
- R3: Pointer mode (bit 29 = 1, bit 28 = 0): exactly one read is issued at word 1. `xfer_addr` is the returned word and `xfer_count` is word 0 bits 23-0.
- R4: Table mode (bit 29 = 0, bit 28 = 1): the first read is at base + sign-extended word 1 bits 23-0, and word 1 bits 31-24 are ignored. `xfer_count` is bits 23-0 of that read, with bits 31-24 dropped, and the count field of word 0 is unused. The second read is at the first address + 4, and its data becomes `xfer_addr`.
- R5: A negative table displacement (word 1 bit 23 = 1) subtracts from the base.
- R6: If word 0 has bits 29 and 28 both set, or bits 31-30 not equal to 00, `illegal` pulses in the cycle after acceptance. No read is issued, `done` does not pulse, and `xfer_count`/`xfer_addr` keep their previous values.
- R7: In table mode the low two bits of the computed table address are forced to 0 on `rd_addr`. `align_err` pulses in the cycle after acceptance exactly when those bits were nonzero.
- R8: The read port waits any number of cycles for `rd_valid`. While it waits, `rd_req` stays 1 and `rd_addr` holds its value.
- R9: While a resolution is in progress `instr_ready` is 0, and a presented instruction is ignored (no extra `done`, outputs unchanged).
- R10: `xfer_phase` equals word 0 bits 26-24 and `xfer_opcode` equals word 0 bit 27 of the resolved instruction, valid from the `done` cycle.
- R11: A base load in the same cycle as an instruction accept takes effect only for later instructions; the table address uses the base held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_load | input | 1 | Load strobe for the data-structure base register |
| base_value | input | 32 | New base value |
| instr_valid | input | 1 | Instruction words presented |
| instr_ready | output | 1 | Block idle and able to accept |
| instr_word0 | input | 32 | Command word |
| instr_word1 | input | 32 | Address, pointer or displacement word |
| rd_req | output | 1 | Read request, held until `rd_valid` |
| rd_addr | output | 32 | Read byte address |
| rd_valid | input | 1 | Read data valid, one cycle per read |
| rd_data | input | 32 | Read data |
| done | output | 1 | One-cycle pulse, operands valid |
| xfer_count | output | 24 | Resolved byte count |
| xfer_addr | output | 32 | Resolved data address |
| xfer_phase | output | 3 | Phase field of the resolved instruction |
| xfer_opcode | output | 1 | Opcode bit of the resolved instruction |
| illegal | output | 1 | One-cycle pulse, instruction rejected |
| align_err | output | 1 | One-cycle pulse, table address was misaligned |

## Verification
The hardest case to reach is the second table read. It is issued at a new address while `rd_req` stays high, right after the count read completes, so a model that waits for the request to fall never sees it. The bench memory answers each read after a random 0-3 cycle delay, up to 20 cycles in one directed case. The address it answers at is recorded every time, so both table reads are compared against bench-computed addresses. Instructions poked at the busy block, and a base load in the accepting cycle, are driven on purpose to show that neither disturbs a resolution already under way.

// File: rtl/bmv_pkg.sv
package bmv_pkg;

  // Field positions inside the command word (neighbour blocks decode these)
  localparam int TYPE_HI   = 31;
  localparam int TYPE_LO   = 30;
  localparam int PTR_BIT   = 29;
  localparam int TAB_BIT   = 28;
  localparam int OPC_BIT   = 27;
  localparam int PHASE_HI  = 26;
  localparam int PHASE_LO  = 24;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'd0,
    MODE_PTR    = 2'd1,
    MODE_TABLE  = 2'd2,
    MODE_BAD    = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_PTR = 2'd1,
    ST_WAIT_CNT = 2'd2,
    ST_WAIT_ADR = 2'd3
  } state_e;

endpackage

// File: rtl/bmv_base_reg.sv
module bmv_base_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] value,
  output logic [DATA_W-1:0] base
);

  always_ff @(posedge clk) begin
    if (rst)       base <= '0;
    else if (load) base <= value;
  end

endmodule

// File: rtl/bmv_decode.sv
module bmv_decode
  import bmv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24,
  parameter int OFS_W  = 24
) (
  input  logic [DATA_W-1:0] word0,
  input  logic [DATA_W-1:0] word1,
  input  logic [DATA_W-1:0] base,
  output mode_e             mode,
  output logic [CNT_W-1:0]  inline_count,
  output logic [2:0]        phase,
  output logic              opcode,
  output logic [DATA_W-1:0] table_addr,
  output logic              misaligned
);

  localparam int BYTES   = DATA_W / 8;
  localparam int ALIGN_W = $clog2(BYTES);

  logic [DATA_W-1:0] disp_ext;
  logic [DATA_W-1:0] raw_sum;
  logic [1:0]        kind;

  // Sign extension of the displacement; upper word-1 bits are dropped
  generate
    if (OFS_W < DATA_W) begin : g_sext
      assign disp_ext = {{(DATA_W-OFS_W){word1[OFS_W-1]}}, word1[OFS_W-1:0]};
    end else begin : g_full
      assign disp_ext = word1;
    end
  endgenerate

  assign raw_sum = base + disp_ext;
  assign kind    = word0[TYPE_HI:TYPE_LO];

  always_comb begin
    if (kind != 2'b00)
      mode = MODE_BAD;
    else begin
      unique case ({word0[PTR_BIT], word0[TAB_BIT]})
        2'b00:   mode = MODE_DIRECT;
        2'b10:   mode = MODE_PTR;
        2'b01:   mode = MODE_TABLE;
        default: mode = MODE_BAD;
      endcase
    end
  end

  assign inline_count = word0[CNT_W-1:0];
  assign phase        = word0[PHASE_HI:PHASE_LO];
  assign opcode       = word0[OPC_BIT];
  assign misaligned   = |raw_sum[ALIGN_W-1:0];
  assign table_addr   = {raw_sum[DATA_W-1:ALIGN_W], {ALIGN_W{1'b0}}};

endmodule

// File: rtl/bmv_fetch_seq.sv
module bmv_fetch_seq
  import bmv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  mode_e             mode,
  input  logic [CNT_W-1:0]  inline_count,
  input  logic [2:0]        phase,
  input  logic              opcode,
  input  logic [DATA_W-1:0] direct_addr,
  input  logic [DATA_W-1:0] table_addr,
  input  logic              misaligned,
  output logic              rd_req,
  output logic [DATA_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [CNT_W-1:0]  xfer_count,
  output logic [DATA_W-1:0] xfer_addr,
  output logic [2:0]        xfer_phase,
  output logic              xfer_opcode,
  output logic              illegal,
  output logic              align_err
);

  localparam int BYTES   = DATA_W / 8;
  localparam int ALIGN_W = $clog2(BYTES);

  state_e           state;
  logic [CNT_W-1:0] cnt_hold;
  logic [2:0]       phase_hold;
  logic             opc_hold;
  logic             accept;

  assign instr_ready = (state == ST_IDLE);
  assign accept      = instr_valid && instr_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt_hold    <= '0;
      phase_hold  <= '0;
      opc_hold    <= 1'b0;
      rd_req      <= 1'b0;
      rd_addr     <= '0;
      done        <= 1'b0;
      illegal     <= 1'b0;
      align_err   <= 1'b0;
      xfer_count  <= '0;
      xfer_addr   <= '0;
      xfer_phase  <= '0;
      xfer_opcode <= 1'b0;
    end else begin
      done      <= 1'b0;
      illegal   <= 1'b0;
      align_err <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            phase_hold <= phase;
            opc_hold   <= opcode;
            cnt_hold   <= inline_count;
            unique case (mode)
              MODE_DIRECT: begin
                xfer_count  <= inline_count;
                xfer_addr   <= direct_addr;
                xfer_phase  <= phase;
                xfer_opcode <= opcode;
                done        <= 1'b1;
              end
              MODE_PTR: begin
                rd_req  <= 1'b1;
                rd_addr <= direct_addr;
                state   <= ST_WAIT_PTR;
              end
              MODE_TABLE: begin
                rd_req    <= 1'b1;
                rd_addr   <= table_addr;
                align_err <= misaligned;
                state     <= ST_WAIT_CNT;
              end
              default: illegal <= 1'b1;
            endcase
          end
        end
        ST_WAIT_CNT: begin
          if (rd_valid) begin
            cnt_hold <= rd_data[CNT_W-1:0];
            rd_addr  <= rd_addr + DATA_W'(BYTES);
            state    <= ST_WAIT_ADR;
          end
        end
        ST_WAIT_PTR, ST_WAIT_ADR: begin
          if (rd_valid) begin
            xfer_addr   <= rd_data;
            xfer_count  <= cnt_hold;
            xfer_phase  <= phase_hold;
            xfer_opcode <= opc_hold;
            done        <= 1'b1;
            rd_req      <= 1'b0;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: a pending read keeps its request and address until answered
  a_r8_req_held: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  // R9: no acceptance while a read is outstanding
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !instr_ready);

  // R6: a rejected instruction produces no read, no done, no new result
  a_r6_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!done && !rd_req && $stable(xfer_count) && $stable(xfer_addr)));

  // R7: table-mode reads are always word aligned
  a_r7_table_aligned: assert property (@(posedge clk) disable iff (rst)
    (rd_req && state != ST_WAIT_PTR) |-> (rd_addr[ALIGN_W-1:0] == '0));

  // R4: the address read follows the count read at the next word
  a_r4_next_word: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_CNT && rd_valid) |=> (rd_req && rd_addr == $past(rd_addr) + DATA_W'(BYTES)));

  // R2: results are only presented once all reads are complete
  a_r2_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!rd_req && instr_ready));

endmodule

// File: rtl/bmove_operand_resolver.sv
module bmove_operand_resolver
  import bmv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24,
  parameter int OFS_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_load,
  input  logic [DATA_W-1:0] base_value,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [DATA_W-1:0] instr_word0,
  input  logic [DATA_W-1:0] instr_word1,
  output logic              rd_req,
  output logic [DATA_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [CNT_W-1:0]  xfer_count,
  output logic [DATA_W-1:0] xfer_addr,
  output logic [2:0]        xfer_phase,
  output logic              xfer_opcode,
  output logic              illegal,
  output logic              align_err
);

  logic [DATA_W-1:0] base_q;
  mode_e             dec_mode;
  logic [CNT_W-1:0]  dec_count;
  logic [2:0]        dec_phase;
  logic              dec_opc;
  logic [DATA_W-1:0] dec_tab;
  logic              dec_mis;

  bmv_base_reg #(.DATA_W(DATA_W)) u_base (
    .clk   (clk),
    .rst   (rst),
    .load  (base_load),
    .value (base_value),
    .base  (base_q)
  );

  bmv_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W), .OFS_W(OFS_W)) u_dec (
    .word0        (instr_word0),
    .word1        (instr_word1),
    .base         (base_q),
    .mode         (dec_mode),
    .inline_count (dec_count),
    .phase        (dec_phase),
    .opcode       (dec_opc),
    .table_addr   (dec_tab),
    .misaligned   (dec_mis)
  );

  bmv_fetch_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .instr_valid  (instr_valid),
    .instr_ready  (instr_ready),
    .mode         (dec_mode),
    .inline_count (dec_count),
    .phase        (dec_phase),
    .opcode       (dec_opc),
    .direct_addr  (instr_word1),
    .table_addr   (dec_tab),
    .misaligned   (dec_mis),
    .rd_req       (rd_req),
    .rd_addr      (rd_addr),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .done         (done),
    .xfer_count   (xfer_count),
    .xfer_addr    (xfer_addr),
    .xfer_phase   (xfer_phase),
    .xfer_opcode  (xfer_opcode),
    .illegal      (illegal),
    .align_err    (align_err)
  );

endmodule

// File: tb/bmove_operand_resolver_test.sv
module bmove_operand_resolver_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_load = 1'b0;
  logic [31:0] base_value = '0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [31:0] instr_word0 = '0;
  logic [31:0] instr_word1 = '0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic        done;
  logic [23:0] xfer_count;
  logic [31:0] xfer_addr;
  logic [2:0]  xfer_phase;
  logic        xfer_opcode;
  logic        illegal;
  logic        align_err;

  int checks = 0;
  int errors = 0;
  logic [31:0] base_model = '0;
  logic [23:0] prev_count = '0;
  logic [31:0] prev_addr  = '0;

  always #4 clk = ~clk;  // 125 MHz

  bmove_operand_resolver uut (
    .clk(clk), .rst(rst), .base_load(base_load), .base_value(base_value),
    .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_word0(instr_word0), .instr_word1(instr_word1),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .xfer_count(xfer_count), .xfer_addr(xfer_addr),
    .xfer_phase(xfer_phase), .xfer_opcode(xfer_opcode),
    .illegal(illegal), .align_err(align_err)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h13572468;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_base(input logic [31:0] v);
    @(negedge clk);
    base_load = 1'b1; base_value = v;
    @(negedge clk);
    base_load = 1'b0;
    base_model = v;
  endtask

  // Issue one instruction and play memory; all expectations from the requirements
  task automatic run(input logic [31:0] w0, input logic [31:0] w1, input int maxw,
                     input bit poke, input bit load_with, input logic [31:0] newbase);
    logic        bad, ptr, tab, exp_align, got_done, inprog;
    int          exp_reads, nrd, done_cyc, wait_left;
    logic [31:0] tsum, taddr, exp_addr, cur, t0, t1;
    logic [23:0] exp_count;
    logic [31:0] seen [2];
    bit          busy_checked;
    bad = (w0[31:30] != 2'b00) || (w0[29] && w0[28]);
    ptr = !bad && w0[29];
    tab = !bad && w0[28];
    tsum  = base_model + {{8{w1[23]}}, w1[23:0]};
    taddr = {tsum[31:2], 2'b00};
    exp_align = tab && (tsum[1:0] != 2'b00);
    t0 = memf(taddr); t1 = memf(taddr + 32'd4);
    if (bad) begin exp_reads = 0; exp_count = prev_count; exp_addr = prev_addr; end
    else if (ptr) begin exp_reads = 1; exp_count = w0[23:0]; exp_addr = memf(w1); end
    else if (tab) begin exp_reads = 2; exp_count = t0[23:0]; exp_addr = t1; end
    else begin exp_reads = 0; exp_count = w0[23:0]; exp_addr = w1; end

    @(negedge clk);
    chk(instr_ready, "R9 ready when idle", {31'd0, instr_ready}, 32'd1);
    instr_valid = 1'b1; instr_word0 = w0; instr_word1 = w1;
    if (load_with) begin base_load = 1'b1; base_value = newbase; end
    @(negedge clk);
    base_load = 1'b0;
    if (load_with) base_model = newbase;
    instr_valid = poke && (exp_reads > 0);
    instr_word0 = 32'h0000_0055; instr_word1 = 32'hDEAD_0000;
    nrd = 0; got_done = 0; done_cyc = -1; inprog = 0; busy_checked = 0; cur = '0;
    wait_left = $urandom_range(0, maxw);
    for (int cyc = 0; cyc < 200; cyc++) begin
      if (cyc == 0) begin
        chk(align_err == exp_align, "R7 align_err pulse", {31'd0, align_err}, {31'd0, exp_align});
        chk(illegal == bad, "R6 illegal pulse", {31'd0, illegal}, {31'd0, bad});
      end
      if (rd_valid) rd_valid = 1'b0;
      if (done) begin got_done = 1; done_cyc = cyc; break; end
      if (bad && cyc >= 3) break;
      if (!bad && exp_reads == 0 && cyc >= 3) break;
      if (rd_req) begin
        if (!busy_checked) begin
          chk(!instr_ready, "R9 not ready while busy", {31'd0, instr_ready}, 32'd0);
          busy_checked = 1;
        end
        if (!inprog) begin inprog = 1; cur = rd_addr; end
        if (wait_left == 0) begin
          chk(rd_addr == cur, "R8 address held while waiting", rd_addr, cur);
          rd_valid = 1'b1; rd_data = memf(rd_addr);
          if (nrd < 2) seen[nrd] = rd_addr;
          nrd++; inprog = 0;
          wait_left = $urandom_range(0, maxw);
        end else wait_left--;
      end
      @(negedge clk);
    end
    instr_valid = 1'b0; rd_valid = 1'b0;

    chk(nrd == exp_reads, "R2/R3/R4/R6 read count", nrd, exp_reads);
    if (bad) begin
      chk(!got_done, "R6 no done on illegal", {31'd0, got_done}, 32'd0);
    end else begin
      chk(got_done, "R2/R3/R4 done pulse", {31'd0, got_done}, 32'd1);
      if (exp_reads == 0) chk(done_cyc == 0, "R2 done one cycle after accept", done_cyc, 0);
      if (ptr && nrd >= 1) chk(seen[0] == w1, "R3 pointer read address", seen[0], w1);
      if (tab && nrd >= 2) begin
        chk(seen[0] == taddr, "R4/R5/R7/R11 count read address", seen[0], taddr);
        chk(seen[1] == taddr + 32'd4, "R4 address read at next word", seen[1], taddr + 32'd4);
      end
      chk(xfer_phase == w0[26:24], "R10 phase", {29'd0, xfer_phase}, {29'd0, w0[26:24]});
      chk(xfer_opcode == w0[27], "R10 opcode", {31'd0, xfer_opcode}, {31'd0, w0[27]});
    end
    chk(xfer_count == exp_count, "R2/R3/R4/R6 count", {8'd0, xfer_count}, {8'd0, exp_count});
    chk(xfer_addr == exp_addr, "R2/R3/R4/R6 address", xfer_addr, exp_addr);
    if (poke && exp_reads > 0) begin
      @(negedge clk);
      chk(!done, "R9 poked instruction ignored", {31'd0, done}, 32'd0);
      chk(xfer_addr == exp_addr, "R9 result unchanged after poke", xfer_addr, exp_addr);
    end
    prev_count = exp_count; prev_addr = exp_addr;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w0, w1, b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(instr_ready, "R1 ready after reset", {31'd0, instr_ready}, 32'd1);
    chk(!done && !rd_req && !illegal && !align_err, "R1 pulses low after reset",
        {28'd0, done, rd_req, illegal, align_err}, 32'd0);
    chk(xfer_count == 24'd0 && xfer_addr == 32'd0, "R1 results zero after reset", xfer_addr, 32'd0);

    set_base(32'h1000_0000);
    run(32'h0B00_0010, 32'h1000_2000, 3, 0, 0, 0);   // R2 direct, R10 phase 3 + opcode
    run(32'h2100_0123, 32'h0000_4001, 3, 0, 0, 0);   // R3 pointer
    run(32'h1600_FFFF, 32'hFF00_0010, 3, 0, 0, 0);   // R4 upper bits ignored
    run(32'h1000_0000, 32'h00FF_FFF0, 3, 0, 0, 0);   // R5 negative offset
    set_base(32'h1000_0002);
    run(32'h1000_0000, 32'h0000_0008, 2, 0, 0, 0);   // R7 misaligned base
    run(32'h3000_0000, 32'h0000_0000, 2, 0, 0, 0);   // R6 both selects
    run(32'h4000_0000, 32'h0000_0000, 2, 0, 0, 0);   // R6 wrong type
    run(32'h2700_0042, 32'h0000_8000, 20, 1, 0, 0);  // R8 long wait, R9 poke
    set_base(32'h2000_0000);
    run(32'h1000_0000, 32'h0000_0010, 3, 1, 1, 32'h3000_0000); // R11 same-cycle load
    run(32'h1000_0000, 32'h0000_0010, 0, 0, 0, 0);   // R11 new base now used

    for (int i = 0; i < 80; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        b = $urandom;
        if ($urandom_range(0, 1) == 1) b[1:0] = 2'b00;
        set_base(b);
      end
      w0 = $urandom;
      if ($urandom_range(0, 9) != 0) w0[31:30] = 2'b00;
      if ($urandom_range(0, 7) != 0) w0[29:28] = 2'($urandom_range(0, 2));
      w1 = $urandom;
      run(w0, w1, 3, $urandom_range(0, 1) == 1, 0, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule